// File: doc/BRIEF.md
# Byte-Addressed 16-bit Up/Down Timer Counter

This block is a 16-bit counter that moves one step on each timer tick: up, down, or back to zero. The tick comes from a clock-select field. It can be off, every cycle, one of four prescaler rates, or one edge direction of an external pin. The pin passes through a synchronizer before it is used.

A CPU with an 8-bit data bus reads and writes the count through two byte locations. The upper byte is never reached directly. Accesses to the high-byte location go to a shared holding register. Reading the low byte fills the holding register with the live upper byte. Writing the low byte loads all 16 bits at once from the bus byte and the holding register. A 16-bit value therefore moves as one unit, even while the counter is running.

The block compares the count against a programmable maximum and against zero. It also sets a sticky overflow request when an upward count wraps. Software clears that request by writing a one to it.

Top module: `cnt16_bytebus`

## Requirements
- R1: A synchronous reset clears the count, the holding register, the overflow request, the prescaler, the synchronizer flops and `bus_rdata`. The next 16-bit read then returns 0x0000 and `at_bottom` is high.
- R2: A read strobe at address 0 puts the count's low byte on `bus_rdata` after the clock edge. On that same edge it copies the count's high byte into the holding register. A read at address 1 returns the holding register, so it keeps the value captured at the low-byte read even if the counter moves in between. A read at address 2 returns the overflow request in bit 0 and zeros above. `bus_rdata` holds its value while no read strobe is present.
- R3: A write to address 1 changes only the holding register; the count is left alone. A write to address 0 loads the count in one edge, with the holding register as bits 15:8 and the bus byte as bits 7:0.
- R4: When a write to address 0 and a timer tick fall on the same edge, the written value is loaded. This holds even when the tick would clear the count, and the tick is lost.
- R5: On a tick, `cnt_clear` high sets the count to zero. Otherwise `cnt_down` high subtracts one and low adds one. The count wraps modulo 2^16.
- R6: With `clk_sel` = 0 the count never changes on its own, but bus reads and writes still work.
- R7: A free-running 10-bit prescaler starts from zero at reset. `clk_sel` = 1 ticks every cycle. Codes 2, 3, 4 and 5 tick once every 8, 64, 256 and 1024 cycles, on the cycle when the prescaler's low 3, 6, 8 or 10 bits are all ones.
- R8: `clk_sel` = 7 counts rising edges of `ext_pin` and `clk_sel` = 6 counts falling edges. The pin goes through two synchronizing flops and an edge detector. A pin change that is set up before clock edge k is counted at edge k+2.
- R9: `at_top` is high exactly while the count equals `top_val`. `at_bottom` is high exactly while the count is zero.
- R10: The overflow request sets when an upward tick, with no clear and no override by a write, takes the count from 0xFFFF to 0x0000. It stays set until a write to address 2 with bit 0 high. If a set and that clear fall on the same edge, the set wins. A downward wrap does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte via holding register, 2 overflow request |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| clk_sel | input | 3 | Tick source: 0 off, 1 system clock, 2..5 prescaled, 6 pin falling, 7 pin rising |
| ext_pin | input | 1 | Asynchronous external count input |
| cnt_clear | input | 1 | Clear the count on the next tick |
| cnt_down | input | 1 | Count down instead of up |
| top_val | input | 16 | Maximum value for the TOP comparison |
| at_top | output | 1 | Count equals `top_val` |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow request |

## Verification
Two pairs of events can land on the same clock edge. The first is a CPU write to the low byte and a timer tick. The bench provokes it by raising the write strobe in the same cycle that `clk_sel` = 1 and `cnt_clear` are asserted. It expects the written 16-bit value with no count step applied. The second is the overflow request being set by a 0xFFFF wrap in the same edge as a write-one-to-clear. The bench expects the request to survive. A behavioural model runs beside the design and judges every cycle's outputs against its own prediction.

// File: rtl/cnt16_pkg.sv
package cnt16_pkg;

  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_SYS      = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_src_e;

  localparam int unsigned NUM_DIVS = 4;
  // log2 of each prescaler ratio, in clock-select order 2..5
  localparam int unsigned DIV_LOG2 [NUM_DIVS] = '{3, 6, 8, 10};

  localparam int unsigned ADDR_LOW  = 0;
  localparam int unsigned ADDR_HIGH = 1;
  localparam int unsigned ADDR_FLAG = 2;

endpackage

// File: rtl/cnt16_tick.sv
module cnt16_tick
  import cnt16_pkg::*;
#(
  parameter int unsigned PRE_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel,
  input  logic       ext_pin,
  output logic       tick
);

  logic [PRE_W-1:0]       pre_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [NUM_DIVS-1:0]    div_hit;
  logic                   synced, pin_rise, pin_fall;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign synced   = sync_q[SYNC_STAGES-1];
  assign pin_rise = synced & ~last_q;
  assign pin_fall = ~synced & last_q;

  for (genvar g = 0; g < NUM_DIVS; g++) begin : g_div
    assign div_hit[g] = &pre_q[DIV_LOG2[g]-1:0];
  end

  always_comb begin
    unique case (clk_src_e'(clk_sel))
      CS_OFF:      tick = 1'b0;
      CS_SYS:      tick = 1'b1;
      CS_DIV8:     tick = div_hit[0];
      CS_DIV64:    tick = div_hit[1];
      CS_DIV256:   tick = div_hit[2];
      CS_DIV1024:  tick = div_hit[3];
      CS_EXT_FALL: tick = pin_fall;
      CS_EXT_RISE: tick = pin_rise;
      default:     tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/cnt16_core.sv
module cnt16_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clear,
  input  logic             down,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_up
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (tick) begin
      if (clear)     cnt_q <= '0;
      else if (down) cnt_q <= cnt_q - 1'b1;
      else           cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count   = cnt_q;
  assign wrap_up = tick & ~clear & ~down & ~load & (&cnt_q);

endmodule

// File: rtl/cnt16_busport.sv
module cnt16_busport
  import cnt16_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap_up,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [BYTE_W-1:0] temp,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag
);

  logic [BYTE_W-1:0] temp_q, rdata_q;
  logic              ovf_q;
  logic              hit_lo, hit_hi, hit_flag;

  assign hit_lo   = (bus_addr == ADDR_W'(ADDR_LOW));
  assign hit_hi   = (bus_addr == ADDR_W'(ADDR_HIGH));
  assign hit_flag = (bus_addr == ADDR_W'(ADDR_FLAG));

  assign load     = bus_wr & hit_lo;
  assign load_val = {temp_q, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst)                    temp_q <= '0;
    else if (bus_wr && hit_hi)  temp_q <= bus_wdata;
    else if (bus_rd && hit_lo)  temp_q <= count[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      if (hit_lo)        rdata_q <= count[BYTE_W-1:0];
      else if (hit_hi)   rdata_q <= temp_q;
      else if (hit_flag) rdata_q <= {{(BYTE_W-1){1'b0}}, ovf_q};
      else               rdata_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   ovf_q <= 1'b0;
    else if (wrap_up)                          ovf_q <= 1'b1;
    else if (bus_wr && hit_flag && bus_wdata[0]) ovf_q <= 1'b0;
  end

  assign temp      = temp_q;
  assign bus_rdata = rdata_q;
  assign ovf_flag  = ovf_q;

endmodule

// File: rtl/cnt16_bytebus.sv
module cnt16_bytebus #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned PRE_W       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [2:0]        clk_sel,
  input  logic              ext_pin,
  input  logic              cnt_clear,
  input  logic              cnt_down,
  input  logic [CNT_W-1:0]  top_val,
  output logic              at_top,
  output logic              at_bottom,
  output logic              ovf_flag
);

  logic             tick_w, load_w, wrap_w;
  logic [CNT_W-1:0] count_w, load_val_w;
  logic [BYTE_W-1:0] temp_w;

  cnt16_tick #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .clk_sel (clk_sel),
    .ext_pin (ext_pin),
    .tick    (tick_w)
  );

  cnt16_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .clear    (cnt_clear),
    .down     (cnt_down),
    .load     (load_w),
    .load_val (load_val_w),
    .count    (count_w),
    .wrap_up  (wrap_w)
  );

  cnt16_busport #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .count     (count_w),
    .wrap_up   (wrap_w),
    .load      (load_w),
    .load_val  (load_val_w),
    .temp      (temp_w),
    .bus_rdata (bus_rdata),
    .ovf_flag  (ovf_flag)
  );

  assign at_top    = (count_w == top_val);
  assign at_bottom = (count_w == '0);

endmodule

// File: rtl/cnt16_bytebus_chk.sv
module cnt16_bytebus_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [2:0]        clk_sel,
  input logic              cnt_clear,
  input logic              cnt_down,
  input logic              tick,
  input logic              wrap,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  count,
  input logic [BYTE_W-1:0] temp
);

  logic wr_lo, wr_hi, wr_flag, rd_lo;
  assign wr_lo   = bus_wr && (bus_addr == ADDR_W'(0));
  assign wr_hi   = bus_wr && (bus_addr == ADDR_W'(1));
  assign wr_flag = bus_wr && (bus_addr == ADDR_W'(2));
  assign rd_lo   = bus_rd && !bus_wr && (bus_addr == ADDR_W'(0));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0 && temp == '0 && !ovf_flag));

  a_r2_low_read_captures: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> temp == $past(count[CNT_W-1:BYTE_W]));

  a_r3_high_write_only_temp: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && clk_sel == 3'd0) |=> (temp == $past(bus_wdata) && count == $past(count)));

  a_r4_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> count == {$past(temp), $past(bus_wdata)});

  a_r5_count_up: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !cnt_clear && !cnt_down) |=> count == $past(count) + 1'b1);

  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !cnt_clear && cnt_down) |=> count == $past(count) - 1'b1);

  a_r6_stopped: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'd0 && !wr_lo) |=> $stable(count));

  a_r10_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_flag);

  a_r10_ovf_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && bus_wdata[0] && !wrap) |=> !ovf_flag);

endmodule

bind cnt16_bytebus cnt16_bytebus_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .clk_sel   (clk_sel),
  .cnt_clear (cnt_clear),
  .cnt_down  (cnt_down),
  .tick      (tick_w),
  .wrap      (wrap_w),
  .ovf_flag  (ovf_flag),
  .count     (count_w),
  .temp      (temp_w)
);

// File: tb/tb_cnt16_bytebus.sv
module tb_cnt16_bytebus;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [2:0] clk_sel;
  logic       ext_pin, cnt_clear, cnt_down;
  logic [15:0] top_val;
  logic       at_top, at_bottom, ovf_flag;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt16_bytebus dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel), .ext_pin(ext_pin),
    .cnt_clear(cnt_clear), .cnt_down(cnt_down), .top_val(top_val),
    .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  // behavioural reference model
  int m_cnt, m_tmp, m_ovf, m_rd, m_pre, m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    int t, nc, nt, nr, no;
    bit wr_lo;
    if (rst) begin
      m_cnt = 0; m_tmp = 0; m_ovf = 0; m_rd = 0; m_pre = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      case (clk_sel)
        3'd0: t = 0;
        3'd1: t = 1;
        3'd2: t = (m_pre % 8 == 7);
        3'd3: t = (m_pre % 64 == 63);
        3'd4: t = (m_pre % 256 == 255);
        3'd5: t = (m_pre % 1024 == 1023);
        3'd6: t = (m_s2 == 0 && m_s3 == 1);
        default: t = (m_s2 == 1 && m_s3 == 0);
      endcase
      wr_lo = bus_wr && bus_addr == 2'd0;
      nc = m_cnt; nt = m_tmp; nr = m_rd; no = m_ovf;
      if (wr_lo) nc = m_tmp * 256 + bus_wdata;
      else if (t != 0) begin
        if (cnt_clear)     nc = 0;
        else if (cnt_down) nc = (m_cnt + 65535) % 65536;
        else               nc = (m_cnt + 1) % 65536;
      end
      if (bus_wr && bus_addr == 2'd1)      nt = bus_wdata;
      else if (bus_rd && bus_addr == 2'd0) nt = m_cnt / 256;
      if (bus_rd) begin
        case (bus_addr)
          2'd0: nr = m_cnt % 256;
          2'd1: nr = m_tmp;
          2'd2: nr = m_ovf;
          default: nr = 0;
        endcase
      end
      if (t != 0 && !wr_lo && !cnt_clear && !cnt_down && m_cnt == 65535) no = 1;
      else if (bus_wr && bus_addr == 2'd2 && bus_wdata[0]) no = 0;
      m_cnt = nc; m_tmp = nt; m_rd = nr; m_ovf = no;
      m_pre = (m_pre + 1) % 1024;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  task automatic chk(string tag, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 rdata", int'(bus_rdata), m_rd);
      chk("R9 at_top", int'(at_top), int'(m_cnt == int'(top_val)));
      chk("R9 at_bottom", int'(at_bottom), int'(m_cnt == 0));
      chk("R10 ovf_flag", int'(ovf_flag), m_ovf);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr8(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd8(input logic [1:0] a, output int v);
    bus_addr = a; bus_rd = 1'b1;
    step();
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd16(output int v);
    int lo, hi;
    rd8(2'd0, lo);
    rd8(2'd1, hi);
    v = hi * 256 + lo;
  endtask

  task automatic wr16(input int v);
    wr8(2'd1, 8'(v / 256));
    wr8(2'd0, 8'(v % 256));
  endtask

  task automatic run(input logic [2:0] sel, input int n);
    clk_sel = sel;
    repeat (n) step();
    clk_sel = 3'd0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v;
    rst = 1'b1; bus_addr = 2'd0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    clk_sel = 3'd0; ext_pin = 1'b0; cnt_clear = 1'b0; cnt_down = 1'b0; top_val = 16'h00FF;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1: reset state
    chk("R1 at_bottom", int'(at_bottom), 1);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    rd16(v); chk("R1 count", v, 16'h0000);

    // R3: high-byte write alone leaves count, low write loads all bits
    wr8(2'd1, 8'h12);
    chk("R3 count unchanged", int'(at_bottom), 1);
    rd16(v); chk("R3 count unchanged", v, 16'h0000);
    wr16(16'h1234);
    rd16(v); chk("R3 16-bit load", v, 16'h1234);

    // R2: holding register keeps the captured high byte while counting
    wr16(16'h12FE);
    rd8(2'd0, v); chk("R2 low byte", v, 8'hFE);
    run(3'd1, 5);
    rd8(2'd1, v); chk("R2 held high byte", v, 8'h12);
    rd16(v); chk("R5 count up", v, 16'h1303);

    // R5: down and clear
    cnt_down = 1'b1; run(3'd1, 4); cnt_down = 1'b0;
    rd16(v); chk("R5 count down", v, 16'h12FF);
    cnt_clear = 1'b1; run(3'd1, 1); cnt_clear = 1'b0;
    rd16(v); chk("R5 clear", v, 16'h0000);

    // R6: stopped source, bus still works
    wr16(16'h0055);
    repeat (30) step();
    rd16(v); chk("R6 stopped", v, 16'h0055);

    // R9: top match
    top_val = 16'h0058;
    run(3'd1, 3);
    chk("R9 at_top", int'(at_top), 1);
    chk("R9 at_bottom low", int'(at_bottom), 0);

    // R4: write beats a clearing tick in the same cycle
    wr8(2'd1, 8'hAB);
    clk_sel = 3'd1; cnt_clear = 1'b1;
    wr8(2'd0, 8'hCD);
    clk_sel = 3'd0; cnt_clear = 1'b0;
    rd16(v); chk("R4 write wins", v, 16'hABCD);

    // R10: up-wrap sets, W1C clears, zero write keeps, set beats clear
    wr16(16'hFFFE);
    run(3'd1, 2);
    rd8(2'd2, v); chk("R10 set on wrap", v, 1);
    wr8(2'd2, 8'h00);
    rd8(2'd2, v); chk("R10 zero write keeps", v, 1);
    wr8(2'd2, 8'h01);
    rd8(2'd2, v); chk("R10 w1c", v, 0);
    cnt_down = 1'b1; run(3'd1, 2); cnt_down = 1'b0;
    rd8(2'd2, v); chk("R10 down wrap no set", v, 0);
    wr16(16'hFFFF);
    clk_sel = 3'd1;
    wr8(2'd2, 8'h01);
    clk_sel = 3'd0;
    rd8(2'd2, v); chk("R10 set beats clear", v, 1);
    wr8(2'd2, 8'h01);

    // R7: prescaled rates
    wr16(16'h0000);
    run(3'd2, 64);
    rd16(v); chk("R7 div8", v, 8);
    run(3'd3, 128);
    rd16(v); chk("R7 div64", v, 10);
    run(3'd4, 512);
    rd16(v); chk("R7 div256", v, 12);
    run(3'd5, 1024);
    rd16(v); chk("R7 div1024", v, 13);

    // R8: external edges
    wr16(16'h0000);
    clk_sel = 3'd7;
    repeat (4) step();
    for (int i = 0; i < 3; i++) begin
      ext_pin = 1'b1; repeat (4) step();
      ext_pin = 1'b0; repeat (4) step();
    end
    repeat (4) step();
    clk_sel = 3'd6;
    for (int i = 0; i < 2; i++) begin
      ext_pin = 1'b1; repeat (4) step();
      ext_pin = 1'b0; repeat (4) step();
    end
    repeat (4) step();
    clk_sel = 3'd0;
    rd16(v); chk("R8 pin edges", v, 5);

    // R8: latency of two edges after the change
    clk_sel = 3'd7;
    ext_pin = 1'b1;
    step();
    chk("R8 not yet", int'(at_top), int'(16'h0005 == top_val));
    top_val = 16'h0006;
    step(); step();
    chk("R8 counted at k+2", int'(at_top), 1);
    clk_sel = 3'd0; ext_pin = 1'b0;
    repeat (4) step();

    summary();
  end

endmodule